// File: doc/BRIEF.md
# Fault-Recovering One-Hot Sequencer

This block is a five-step ring controller. Its state lives in a five-bit register that holds an explicit one-hot code rather than an abstract enumeration. The idle code is `00001`. While `advance` is high, the single hot bit moves one place toward the MSB on every clock, and from `10000` it wraps back to idle. While `advance` is low, the register keeps its value.

Every one of the 32 values the register can hold has a defined successor. A value with no bit set, or with two or more bits set, returns the register to idle on the next edge. The machine does not go to the nearest legal code, and it does not stop at zero. A registered error flag goes high for one cycle after the register held such a value. A load port writes any five-bit value into the register. This port lets a test inject faults, and because illegal values can really be reached through it, synthesis cannot remove the recovery logic as unreachable.

Top module: `safe_ring_fsm`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes `00001` and `err_o` becomes 0 after that edge.
- R2: With `rst` and `load_en` low, `advance` high and a legal state, the state steps from `00001` to `00010`, `00100`, `01000`, `10000`, and then back to `00001`, one step per edge.
- R3: With `rst`, `load_en` and `advance` low and a legal state, the state does not change.
- R4: If the state is `00000` and `load_en` is low, the next edge sets the state to `00001`, whatever `advance` is.
- R5: If the state has two or more bits set and `load_en` is low, the next edge sets the state to `00001`. It does not move to any single-bit code that is nearer in Hamming distance.
- R6: With `load_en` high and `rst` low, the next edge copies `load_val` into the state. This takes priority over both stepping and recovery.
- R7: After each edge without reset, `err_o` is 1 exactly when the state held just before that edge was not a single-bit code, and 0 otherwise.
- R8: Reset takes priority over `load_en`. A load requested during reset is discarded, and the error flag is cleared even if the state was illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Step to the next legal state |
| load_en | input | 1 | Write `load_val` into the state register |
| load_val | input | 5 | Value to write, may be illegal |
| state_o | output | 5 | Current state register, one-hot when legal |
| err_o | output | 1 | One-cycle flag: the previous state was illegal |

## Verification
An illegal state never arises from the stepping logic, so the only way to reach one from the ports is the load path. The bench loads the all-zero code and several multi-hot codes (adjacent pairs, a wrap-around pair, all ones), then watches the following edge to see the return to idle and the error pulse. It also loads a new value while the register already holds an illegal one, which shows that load takes priority over recovery. Finally, it asserts reset together with a pending load while the state is illegal, which shows that reset takes priority over both.

// File: rtl/safe_ring_pkg.sv
package safe_ring_pkg;

    // Number of ring positions; the register is one bit per position.
    localparam int unsigned SR_NSTATE = 5;
    localparam int unsigned SR_SELW   = 2;

    typedef logic [SR_NSTATE-1:0] sr_code_t;

    localparam sr_code_t SR_IDLE = sr_code_t'(1);

    // Which source feeds the state register on the next edge.
    typedef enum logic [SR_SELW-1:0] {
        SR_SEL_HOLD    = 2'd0,
        SR_SEL_STEP    = 2'd1,
        SR_SEL_RECOVER = 2'd2,
        SR_SEL_LOAD    = 2'd3
    } sr_sel_t;

    // Decision bundle produced by the next-state logic.
    typedef struct packed {
        sr_sel_t  sel;
        sr_code_t nxt;
        logic     bad;
    } sr_dec_t;

    // Move the hot bit one place toward the MSB, wrapping to bit 0.
    function automatic sr_code_t sr_rotate(input sr_code_t c);
        return {c[SR_NSTATE-2:0], c[SR_NSTATE-1]};
    endfunction

endpackage

// File: rtl/sr_legal_det.sv
module sr_legal_det
    import safe_ring_pkg::*;
(
    input  sr_code_t code_i,
    output logic     legal_o
);
    // Ripple scan: "seen one" and "seen two or more" chains.
    logic [SR_NSTATE-1:0] seen_one;
    logic [SR_NSTATE-1:0] seen_two;

    assign seen_one[0] = code_i[0];
    assign seen_two[0] = 1'b0;

    generate
        for (genvar i = 1; i < SR_NSTATE; i++) begin : g_scan
            assign seen_one[i] = seen_one[i-1] | code_i[i];
            assign seen_two[i] = seen_two[i-1] | (seen_one[i-1] & code_i[i]);
        end
    endgenerate

    assign legal_o = seen_one[SR_NSTATE-1] & ~seen_two[SR_NSTATE-1];

endmodule

// File: rtl/sr_next_logic.sv
module sr_next_logic
    import safe_ring_pkg::*;
(
    input  sr_code_t cur_i,
    input  logic     advance_i,
    input  logic     load_en_i,
    input  sr_code_t load_val_i,
    output sr_dec_t  dec_o
);
    logic legal;

    sr_legal_det u_det (
        .code_i  (cur_i),
        .legal_o (legal)
    );

    // Priority: load, then recovery, then step, then hold.
    always_comb begin
        dec_o.bad = ~legal;
        if (load_en_i) begin
            dec_o.sel = SR_SEL_LOAD;
        end else if (!legal) begin
            dec_o.sel = SR_SEL_RECOVER;
        end else if (advance_i) begin
            dec_o.sel = SR_SEL_STEP;
        end else begin
            dec_o.sel = SR_SEL_HOLD;
        end

        unique case (dec_o.sel)
            SR_SEL_LOAD:    dec_o.nxt = load_val_i;
            SR_SEL_RECOVER: dec_o.nxt = SR_IDLE;
            SR_SEL_STEP:    dec_o.nxt = sr_rotate(cur_i);
            default:        dec_o.nxt = cur_i;
        endcase
    end

endmodule

// File: rtl/sr_state_reg.sv
module sr_state_reg
    import safe_ring_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sr_code_t nxt_i,
    output sr_code_t q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= SR_IDLE;
        end else begin
            q_o <= nxt_i;
        end
    end

endmodule

// File: rtl/sr_err_flag.sv
module sr_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic bad_i,
    output logic err_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_o <= 1'b0;
        end else begin
            err_o <= bad_i;
        end
    end

endmodule

// File: rtl/safe_ring_fsm.sv
module safe_ring_fsm
    import safe_ring_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 advance,
    input  logic                 load_en,
    input  logic [SR_NSTATE-1:0] load_val,
    output logic [SR_NSTATE-1:0] state_o,
    output logic                 err_o
);
    sr_code_t cur_q;
    sr_dec_t  dec;

    sr_next_logic u_next (
        .cur_i      (cur_q),
        .advance_i  (advance),
        .load_en_i  (load_en),
        .load_val_i (load_val),
        .dec_o      (dec)
    );

    sr_state_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .nxt_i (dec.nxt),
        .q_o   (cur_q)
    );

    sr_err_flag u_err (
        .clk   (clk),
        .rst   (rst),
        .bad_i (dec.bad),
        .err_o (err_o)
    );

    assign state_o = cur_q;

endmodule

// File: rtl/sr_chk.sv
module sr_chk
    import safe_ring_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 advance,
    input logic                 load_en,
    input logic [SR_NSTATE-1:0] load_val,
    input logic [SR_NSTATE-1:0] state_o,
    input logic                 err_o
);
    logic     one_hot;
    sr_code_t rot_exp;

    assign one_hot = ($countones(state_o) == 1);
    assign rot_exp = sr_rotate(state_o);

    // R2
    step_ring_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && advance && one_hot) |=> state_o == $past(rot_exp));

    // R3
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !advance && one_hot) |=> $stable(state_o));

    // R4
    zero_recover_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && state_o == '0) |=> state_o == SR_IDLE);

    // R5
    multi_recover_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_en && $countones(state_o) > 1) |=> state_o == SR_IDLE);

    // R6
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> state_o == $past(load_val));

    // R7
    err_raise_chk: assert property (@(posedge clk) disable iff (rst)
        !one_hot |=> err_o);

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        one_hot |=> !err_o);

endmodule

bind safe_ring_fsm sr_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .advance  (advance),
    .load_en  (load_en),
    .load_val (load_val),
    .state_o  (state_o),
    .err_o    (err_o)
);

// File: tb/safe_ring_fsm_tb.sv
module safe_ring_fsm_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       advance = 1'b0;
    logic       load_en = 1'b0;
    logic [4:0] load_val = 5'b0;
    logic [4:0] state_o;
    logic       err_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    safe_ring_fsm u_dut (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .load_en  (load_en),
        .load_val (load_val),
        .state_o  (state_o),
        .err_o    (err_o)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive on the falling edge, then sample just after the next rising edge.
    task automatic step(input logic r, input logic adv, input logic ld, input logic [4:0] v);
        @(negedge clk);
        rst = r;
        advance = adv;
        load_en = ld;
        load_val = v;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        step(1'b1, 1'b1, 1'b0, 5'b0);
        step(1'b1, 1'b0, 1'b0, 5'b0);
        check("R1 state", state_o, 5'b00001);
        check("R1 err", {4'b0, err_o}, 5'd0);
    endtask

    task automatic t_ring;
        logic [4:0] exp_seq [5] = '{5'b00010, 5'b00100, 5'b01000, 5'b10000, 5'b00001};
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b1, 1'b0, 5'b0);
            check("R2 ring", state_o, exp_seq[i]);
            check("R7 no err", {4'b0, err_o}, 5'd0);
        end
    endtask

    task automatic t_hold;
        step(1'b0, 1'b1, 1'b0, 5'b0);
        step(1'b0, 1'b1, 1'b0, 5'b0);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0, 1'b0, 5'b0);
            check("R3 hold", state_o, 5'b00100);
        end
    endtask

    task automatic t_zero;
        step(1'b0, 1'b1, 1'b1, 5'b00000);
        check("R6 load zero", state_o, 5'b00000);
        check("R7 err before", {4'b0, err_o}, 5'd0);
        step(1'b0, 1'b1, 1'b0, 5'b0);
        check("R4 zero recover", state_o, 5'b00001);
        check("R7 err pulse", {4'b0, err_o}, 5'd1);
        step(1'b0, 1'b0, 1'b0, 5'b0);
        check("R7 err clears", {4'b0, err_o}, 5'd0);
        check("R3 idle hold", state_o, 5'b00001);
    endtask

    task automatic t_multi;
        logic [4:0] pats [4] = '{5'b00110, 5'b11111, 5'b10001, 5'b01100};
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b1, 1'b1, pats[i]);
            check("R6 load multi", state_o, pats[i]);
            step(1'b0, 1'b1, 1'b0, 5'b0);
            check("R5 multi recover", state_o, 5'b00001);
            check("R7 err multi", {4'b0, err_o}, 5'd1);
        end
    endtask

    task automatic t_load_prio;
        step(1'b0, 1'b0, 1'b1, 5'b00110);
        step(1'b0, 1'b1, 1'b1, 5'b01000);
        check("R6 load over recover", state_o, 5'b01000);
        check("R7 err under load", {4'b0, err_o}, 5'd1);
        step(1'b0, 1'b1, 1'b0, 5'b0);
        check("R2 after load", state_o, 5'b10000);
        step(1'b0, 1'b1, 1'b1, 5'b00100);
        check("R6 load over step", state_o, 5'b00100);
    endtask

    task automatic t_rst_prio;
        step(1'b0, 1'b0, 1'b1, 5'b11000);
        step(1'b1, 1'b1, 1'b1, 5'b10000);
        check("R8 reset over load", state_o, 5'b00001);
        check("R8 err cleared", {4'b0, err_o}, 5'd0);
        step(1'b0, 1'b0, 1'b0, 5'b0);
        check("R8 after reset", state_o, 5'b00001);
    endtask

    initial begin
        t_reset();
        t_ring();
        t_hold();
        t_zero();
        t_multi();
        t_load_prio();
        t_rst_prio();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule